// File: doc/BRIEF.md
# Precise Exception Controller for an In-Order Pipeline

This block sits next to the control path of a five-stage in-order pipeline and takes precise exceptions. Two stages can raise a fault. The decode stage reports an undefined opcode and the execute stage reports an arithmetic overflow. Each stage supplies the address that follows the faulting instruction, which is its PC plus 4. In any one cycle the controller accepts at most one fault, and it picks the one from the older instruction. In that same cycle it squashes the faulting instruction and every younger instruction. The instructions ahead of the fault are left to complete. The controller also drives a PC load request together with the handler address, and the fetch stage's PC register takes that address on the next clock.

On acceptance the block records the faulting instruction's PC plus 4 in an exception-PC register and records a one-bit cause code. It then sets an exception-level flag, and no further faults are accepted while this flag is set. The handler entry comes in two forms, chosen by a mode pin. One is a single fixed entry point. The other is a vectored entry whose address is picked by the cause. To finish handling, the handler pulses a return strobe. The block then requests a refetch from the recorded address minus 4, which restarts the faulting instruction, and it clears the exception-level flag.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, excLevel, epcOut and causeOut are all 0, and pcLoad, flushIf, flushId and flushEx stay low while no fault or return is requested.
- R2: With excLevel low and only idFault high, flushIf and flushId go high and flushEx stays low, all in that same cycle. pcLoad is also high in that cycle. On the next edge causeOut becomes 0, which is the code for undefined opcode.
- R3: With excLevel low and only exFault high, flushIf, flushId and flushEx all go high in that same cycle, and pcLoad is high. On the next edge causeOut becomes 1, which is the code for overflow.
- R4: If idFault and exFault are both high while excLevel is low, the execute-stage fault is taken. All three flushes go high, and on the next edge epcOut takes exPcPlus4 and causeOut takes 1.
- R5: On the edge after an accepted fault, epcOut holds the PC-plus-4 value supplied by the winning stage, without change.
- R6: When vectorMode is 0, pcTarget during an accepted fault is 0x8000_0180 whatever the cause.
- R7: When vectorMode is 1, pcTarget during an accepted fault is 0xC000_0000 plus 0x20 times the cause. That gives 0xC000_0000 for an undefined opcode and 0xC000_0020 for an overflow.
- R8: While excLevel is high, idFault and exFault have no effect. No flush or pcLoad is raised, and epcOut and causeOut keep their values.
- R9: When eret is high while excLevel is high, pcLoad goes high in that cycle with pcTarget equal to epcOut minus 4. excLevel falls on the next edge.
- R10: When eret is high while excLevel is low, nothing happens. pcLoad stays low, excLevel stays low and epcOut does not change.
- R11: excLevel rises on the edge after a fault is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vectorMode | input | 1 | 0 selects the fixed handler entry, 1 selects the cause-vectored entry |
| idFault | input | 1 | Decode stage reports an undefined opcode |
| idPcPlus4 | input | 32 | PC plus 4 of the instruction in decode |
| exFault | input | 1 | Execute stage reports an arithmetic overflow |
| exPcPlus4 | input | 32 | PC plus 4 of the instruction in execute |
| eret | input | 1 | Return strobe from the handler |
| flushIf | output | 1 | Squash the fetch stage |
| flushId | output | 1 | Squash the decode stage |
| flushEx | output | 1 | Squash the execute stage |
| pcLoad | output | 1 | Load the PC with pcTarget at the next clock |
| pcTarget | output | 32 | Handler entry or restart address |
| epcOut | output | 32 | Recorded PC plus 4 of the faulting instruction |
| causeOut | output | 1 | Recorded cause: 0 for undefined opcode, 1 for overflow |
| excLevel | output | 1 | Set while a handler is running, masks new faults |

## Verification
The hardest case to reach is a fault that arrives while a handler is already running. The ports must show that the fault leaves no trace at all: no flush, no PC load, and no change to the recorded address or cause. To get there, the bench first drives a genuine fault so that excLevel is set. It then presents an execute-stage fault with a different address and a cause of its own, and it checks the outputs in that cycle and again after the next edge. The same-cycle collision of both stages is reached from the vector table, in both handler modes, using distinct addresses per stage so that the winner can be seen in epcOut.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_CAUSES = 2;
  localparam int CAUSE_W    = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1;

  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_OVFL  = CAUSE_W'(1);

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // record EPC and cause this edge
    logic selEx;    // execute-stage fault is the winner
    logic restart;  // return path: drive refetch address
  } ctrlStrobes_t;
endpackage

// File: rtl/exc_control.sv
module exc_control
  import exc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         idFault,
  input  logic         exFault,
  input  logic         eret,
  output ctrlStrobes_t strobes,
  output logic         flushIf,
  output logic         flushId,
  output logic         flushEx,
  output logic         pcLoad,
  output logic         excLevel
);
  logic levelQ;
  logic take;
  logic restart;

  // the execute-stage instruction is older, so it outranks decode
  assign take    = !levelQ && (idFault || exFault);
  assign restart = levelQ && eret;

  always_comb begin
    strobes.capture = take;
    strobes.selEx   = exFault;
    strobes.restart = restart;
  end

  assign flushIf  = take;
  assign flushId  = take;
  assign flushEx  = take && exFault;
  assign pcLoad   = take || restart;
  assign excLevel = levelQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b0;
    end else if (take) begin
      levelQ <= 1'b1;
    end else if (restart) begin
      levelQ <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int                XLEN        = 32,
  parameter logic [XLEN-1:0]   FIXED_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0]   VEC_BASE    = 32'hC000_0000,
  parameter logic [XLEN-1:0]   VEC_STRIDE  = 32'h0000_0020,
  parameter logic [XLEN-1:0]   INSN_BYTES  = 32'd4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vectorMode,
  input  ctrlStrobes_t       strobes,
  input  logic [XLEN-1:0]    idPcPlus4,
  input  logic [XLEN-1:0]    exPcPlus4,
  output logic [XLEN-1:0]    pcTarget,
  output logic [XLEN-1:0]    epcOut,
  output logic [CAUSE_W-1:0] causeOut
);
  logic [XLEN-1:0]    epcQ;
  logic [CAUSE_W-1:0] causeQ;
  logic [CAUSE_W-1:0] selCause;
  logic [XLEN-1:0]    selPc;
  logic [XLEN-1:0]    vecAddr [NUM_CAUSES];

  // vector entries computed from base and stride
  for (genvar g = 0; g < NUM_CAUSES; g++) begin : gVec
    assign vecAddr[g] = VEC_BASE + XLEN'(g) * VEC_STRIDE;
  end

  assign selCause = strobes.selEx ? CAUSE_OVFL : CAUSE_UNDEF;
  assign selPc    = strobes.selEx ? exPcPlus4 : idPcPlus4;

  always_comb begin
    if (strobes.restart) begin
      pcTarget = epcQ - INSN_BYTES;
    end else if (vectorMode) begin
      pcTarget = vecAddr[selCause];
    end else begin
      pcTarget = FIXED_ENTRY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ   <= '0;
      causeQ <= '0;
    end else if (strobes.capture) begin
      epcQ   <= selPc;
      causeQ <= selCause;
    end
  end

  assign epcOut   = epcQ;
  assign causeOut = causeQ;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vectorMode,
  input  logic               idFault,
  input  logic [XLEN-1:0]    idPcPlus4,
  input  logic               exFault,
  input  logic [XLEN-1:0]    exPcPlus4,
  input  logic               eret,
  output logic               flushIf,
  output logic               flushId,
  output logic               flushEx,
  output logic               pcLoad,
  output logic [XLEN-1:0]    pcTarget,
  output logic [XLEN-1:0]    epcOut,
  output logic [CAUSE_W-1:0] causeOut,
  output logic               excLevel
);
  ctrlStrobes_t strobes;

  exc_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .idFault  (idFault),
    .exFault  (exFault),
    .eret     (eret),
    .strobes  (strobes),
    .flushIf  (flushIf),
    .flushId  (flushId),
    .flushEx  (flushEx),
    .pcLoad   (pcLoad),
    .excLevel (excLevel)
  );

  exc_datapath #(
    .XLEN        (XLEN),
    .FIXED_ENTRY (FIXED_ENTRY),
    .VEC_BASE    (VEC_BASE),
    .VEC_STRIDE  (VEC_STRIDE),
    .INSN_BYTES  (XLEN'(4))
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .vectorMode (vectorMode),
    .strobes    (strobes),
    .idPcPlus4  (idPcPlus4),
    .exPcPlus4  (exPcPlus4),
    .pcTarget   (pcTarget),
    .epcOut     (epcOut),
    .causeOut   (causeOut)
  );
endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
  import exc_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180
) (
  input logic               clk,
  input logic               rstN,
  input logic               vectorMode,
  input logic               idFault,
  input logic [XLEN-1:0]    idPcPlus4,
  input logic               exFault,
  input logic [XLEN-1:0]    exPcPlus4,
  input logic               eret,
  input logic               flushIf,
  input logic               flushId,
  input logic               flushEx,
  input logic               pcLoad,
  input logic [XLEN-1:0]    pcTarget,
  input logic [XLEN-1:0]    epcOut,
  input logic [CAUSE_W-1:0] causeOut,
  input logic               excLevel
);
  a_r2_id_flush: assert property (@(posedge clk) disable iff (!rstN)
    (idFault && !exFault && !excLevel) |-> (flushIf && flushId && !flushEx && pcLoad));

  a_r3_ex_flush: assert property (@(posedge clk) disable iff (!rstN)
    (exFault && !excLevel) |-> (flushIf && flushId && flushEx && pcLoad));

  a_r4_ex_wins: assert property (@(posedge clk) disable iff (!rstN)
    (exFault && idFault && !excLevel) |=> (epcOut == $past(exPcPlus4) && causeOut == 1'b1));

  a_r5_id_epc: assert property (@(posedge clk) disable iff (!rstN)
    (idFault && !exFault && !excLevel) |=> (epcOut == $past(idPcPlus4)));

  a_r6_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !excLevel && !vectorMode) |-> (pcTarget == FIXED_ENTRY));

  a_r8_masked: assert property (@(posedge clk) disable iff (!rstN)
    (excLevel && !eret) |-> (!pcLoad && !flushIf && !flushId && !flushEx));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    excLevel |=> ($stable(epcOut) && $stable(causeOut)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (excLevel && eret) |=> !excLevel);

  a_r11_level: assert property (@(posedge clk) disable iff (!rstN)
    (!excLevel && (idFault || exFault)) |=> excLevel);
endmodule

bind exc_ctrl exc_ctrl_checker #(
  .XLEN        (XLEN),
  .FIXED_ENTRY (FIXED_ENTRY)
) u_checker (.*);

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        mode;
    logic        idF;
    logic        exF;
    logic [31:0] idPc;
    logic [31:0] exPc;
    logic [2:0]  flush;   // {ex, id, if}
    logic [31:0] target;
    logic [31:0] epc;
    logic        cause;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 32'h0040_0004, 32'h0, 3'b011, 32'h8000_0180, 32'h0040_0004, 1'b0},
    '{1'b0, 1'b0, 1'b1, 32'h0, 32'h0040_004C, 3'b111, 32'h8000_0180, 32'h0040_004C, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'h0040_0050, 32'h0040_004C, 3'b111, 32'h8000_0180, 32'h0040_004C, 1'b1},
    '{1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0, 3'b011, 32'hC000_0000, 32'h0000_1000, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_2004, 3'b111, 32'hC000_0020, 32'h0000_2004, 1'b1},
    '{1'b1, 1'b1, 1'b1, 32'h0000_3008, 32'h0000_3004, 3'b111, 32'hC000_0020, 32'h0000_3004, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vectorMode = 1'b0;
  logic        idFault = 1'b0;
  logic [31:0] idPcPlus4 = '0;
  logic        exFault = 1'b0;
  logic [31:0] exPcPlus4 = '0;
  logic        eret = 1'b0;
  logic        flushIf, flushId, flushEx, pcLoad, excLevel;
  logic [31:0] pcTarget, epcOut;
  logic [0:0]  causeOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_ctrl u_exc_ctrl (
    .clk(clk), .rstN(rstN), .vectorMode(vectorMode),
    .idFault(idFault), .idPcPlus4(idPcPlus4),
    .exFault(exFault), .exPcPlus4(exPcPlus4), .eret(eret),
    .flushIf(flushIf), .flushId(flushId), .flushEx(flushEx),
    .pcLoad(pcLoad), .pcTarget(pcTarget), .epcOut(epcOut),
    .causeOut(causeOut), .excLevel(excLevel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 excLevel", {31'b0, excLevel}, 32'h0);
    check("R1 epc", epcOut, 32'h0);
    check("R1 cause", {31'b0, causeOut}, 32'h0);
    check("R1 idle outputs", {28'b0, pcLoad, flushEx, flushId, flushIf}, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7 R9 R11
    for (int i = 0; i < NV; i++) begin
      vectorMode = VECS[i].mode;
      idFault    = VECS[i].idF;
      exFault    = VECS[i].exF;
      idPcPlus4  = VECS[i].idPc;
      exPcPlus4  = VECS[i].exPc;
      #1;
      check("R2/R3/R4 flush", {29'b0, flushEx, flushId, flushIf}, {29'b0, VECS[i].flush});
      check("R2/R3 pcLoad", {31'b0, pcLoad}, 32'h1);
      check("R6/R7 target", pcTarget, VECS[i].target);
      tick();
      idFault = 1'b0;
      exFault = 1'b0;
      #1;
      check("R11 level set", {31'b0, excLevel}, 32'h1);
      check("R5 epc", epcOut, VECS[i].epc);
      check("R4 cause", {31'b0, causeOut}, {31'b0, VECS[i].cause});
      eret = 1'b1;
      #1;
      check("R9 restart load", {31'b0, pcLoad}, 32'h1);
      check("R9 restart target", pcTarget, VECS[i].epc - 32'd4);
      tick();
      eret = 1'b0;
      #1;
      check("R9 level clear", {31'b0, excLevel}, 32'h0);
    end

    // R8: fault while handler runs is masked
    vectorMode = 1'b0;
    idFault = 1'b1;
    idPcPlus4 = 32'h0000_0104;
    tick();
    idFault = 1'b0;
    exFault = 1'b1;
    exPcPlus4 = 32'h0000_0AA8;
    #1;
    check("R8 no flush", {29'b0, flushEx, flushId, flushIf}, 32'h0);
    check("R8 no pcLoad", {31'b0, pcLoad}, 32'h0);
    tick();
    exFault = 1'b0;
    #1;
    check("R8 epc kept", epcOut, 32'h0000_0104);
    check("R8 cause kept", {31'b0, causeOut}, 32'h0);
    check("R8 level kept", {31'b0, excLevel}, 32'h1);
    eret = 1'b1;
    tick();
    eret = 1'b0;
    #1;

    // R10: return with no exception pending is ignored
    eret = 1'b1;
    #1;
    check("R10 no pcLoad", {31'b0, pcLoad}, 32'h0);
    tick();
    eret = 1'b0;
    #1;
    check("R10 level low", {31'b0, excLevel}, 32'h0);
    check("R10 epc kept", epcOut, 32'h0000_0104);

    // R1 idle: no request, no action
    check("R1 idle pcLoad", {31'b0, pcLoad}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule